// File: doc/BRIEF.md
# Result Dispatch and Method Sender

This block is the write-back end of a small command-macro engine. For each instruction that has finished executing, it takes the instruction word and the execute result. It then carries out one of eight result operations. Each operation is a fixed mix of four actions: write the result into the register file, pop the next input parameter from a parameter queue, load a method address register, and send an (address, data) method write on a valid/ready output port. The eight-entry register file sits inside the block. Two read ports, indexed from the instruction's source fields, feed the execute stage.

A method address holds a 12-bit target address and a 6-bit step. After every send, the address advances by the step and wraps modulo 4096. A start command begins a macro. It clears the register file and the method address, then loads the first queued parameter into register 1, so later fetches begin with the second parameter. A fetch from an empty queue, or a send that the consumer does not accept, holds the block in place. A one-cycle done pulse marks the end of each command.

Top module: `mthd_dispatch`

## Requirements
- R1: After reset, cmd_ready is 1, done, snd_valid and prm_pop are 0, and every register reads as zero.
- R2: A command with cmd_start set clears all registers, sets the method address and step to zero, then pops one parameter into register 1, with no send.
- R3: The result operation is taken from instruction bits [6:4] and the destination from bits [10:8]; src_a_data and src_b_data show the registers indexed by bits [13:11] and [16:14].
- R4: Operation 1 writes the result to the destination; operation 0 writes a popped parameter to the destination and discards the result. Neither sends.
- R5: Operation 2 writes the result to the destination and loads it as the method address (bits [11:0] address, bits [17:12] step), with no send.
- R6: Operation 3 writes a popped parameter to the destination and sends the result; operation 4 writes the result to the destination and sends it.
- R7: Operation 5 writes a popped parameter to the destination and loads the result as the method address, with no send.
- R8: Operation 6 writes the result, loads it as the method address, then sends a newly popped parameter to the new address.
- R9: Operation 7 writes the result, loads it as the method address, then sends result bits [17:12], zero-extended, to the new address.
- R10: Register 0 always reads as zero, and a write to it is dropped (a parameter it would have taken is still popped).
- R11: Each accepted send uses the current address, after which the address becomes (address + step) mod 4096.
- R12: While a fetch waits on an empty queue, prm_pop stays 0. While a send is not accepted, snd_valid stays 1 and snd_addr and snd_data hold. prm_pop is never 1 while prm_valid is 0.
- R13: cmd_ready is 0 from the cycle after a command is accepted until it completes; done is high for exactly one cycle per command, after its register write is visible.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Block idle, command accepted this cycle if valid |
| cmd_start | input | 1 | Command is a macro start |
| cmd_insn | input | INSN_W | Instruction word (operation, destination, source fields) |
| cmd_result | input | DATA_W | Execute result |
| src_a_data | output | DATA_W | Register indexed by source A field |
| src_b_data | output | DATA_W | Register indexed by source B field |
| prm_valid | input | 1 | Parameter queue not empty |
| prm_data | input | DATA_W | Head of parameter queue |
| prm_pop | output | 1 | Pop the queue head |
| snd_valid | output | 1 | Method write offered |
| snd_ready | input | 1 | Method write accepted |
| snd_addr | output | ADDR_W | Method write address |
| snd_data | output | DATA_W | Method write data |
| done | output | 1 | One-cycle completion pulse |

## Verification
The bench builds the block with its default parameters: 32-bit data, eight registers, a 12-bit address and a 6-bit step. With these values, a step of 5 from address 0xFFE moves the address past its top and back to 0x003, so the wrap is reached with two sends. A 6-bit step lets operation 7 send a full-width field value (0x2A). Eight registers means every destination code, including register 0, maps onto a real entry.

// File: rtl/mthd_pkg.sv
package mthd_pkg;

   // instruction field positions, fixed by the encoding
   localparam int OP_LSB  = 4;
   localparam int DST_LSB = 8;
   localparam int SA_LSB  = 11;
   localparam int SB_LSB  = 14;
   localparam int FLD_W   = 3;
   localparam int INSN_MIN_W = SB_LSB + FLD_W;

   typedef enum logic [2:0] {
      RO_FETCH        = 3'd0,
      RO_MOVE         = 3'd1,
      RO_MOVE_LDM     = 3'd2,
      RO_FETCH_SEND   = 3'd3,
      RO_MOVE_SEND    = 3'd4,
      RO_FETCH_LDM    = 3'd5,
      RO_MOVE_LDM_FSD = 3'd6,
      RO_MOVE_LDM_STP = 3'd7
   } res_op_e;

   typedef enum logic [1:0] {
      SS_RESULT = 2'd0,
      SS_PARAM  = 2'd1,
      SS_STEP   = 2'd2
   } send_src_e;

   typedef struct packed {
      logic      fetch;
      logic      wr_param;
      logic      load_m;
      logic      send;
      send_src_e src;
   } op_ctl_t;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_FETCH = 2'd1,
      ST_APPLY = 2'd2,
      ST_SEND  = 2'd3
   } dsp_state_e;

   function automatic op_ctl_t decode_op(input res_op_e op);
      op_ctl_t c;
      c = '{fetch: 1'b0, wr_param: 1'b0, load_m: 1'b0, send: 1'b0, src: SS_RESULT};
      case (op)
         RO_FETCH:        begin c.fetch = 1'b1; c.wr_param = 1'b1; end
         RO_MOVE:         ;
         RO_MOVE_LDM:     c.load_m = 1'b1;
         RO_FETCH_SEND:   begin c.fetch = 1'b1; c.wr_param = 1'b1; c.send = 1'b1; end
         RO_MOVE_SEND:    c.send = 1'b1;
         RO_FETCH_LDM:    begin c.fetch = 1'b1; c.wr_param = 1'b1; c.load_m = 1'b1; end
         RO_MOVE_LDM_FSD: begin c.fetch = 1'b1; c.load_m = 1'b1; c.send = 1'b1; c.src = SS_PARAM; end
         RO_MOVE_LDM_STP: begin c.load_m = 1'b1; c.send = 1'b1; c.src = SS_STEP; end
         default:         ;
      endcase
      return c;
   endfunction

endpackage

// File: rtl/mthd_regfile.sv
module mthd_regfile #(
   parameter int DATA_W = 32,
   parameter int NREG   = 8,
   parameter int IDX_W  = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              we,
   input  logic [IDX_W-1:0]  widx,
   input  logic [DATA_W-1:0] wdata,
   input  logic [IDX_W-1:0]  ra_idx,
   input  logic [IDX_W-1:0]  rb_idx,
   output logic [DATA_W-1:0] ra_data,
   output logic [DATA_W-1:0] rb_data
);

   logic [DATA_W-1:0] rf [NREG];

   for (genvar g = 0; g < NREG; g++) begin : g_reg
      if (g == 0) begin : g_zero
         assign rf[g] = '0;
      end else begin : g_flop
         logic [DATA_W-1:0] q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                                q <= '0;
            else if (clr)                              q <= '0;
            else if (we && (widx == IDX_W'(g)))        q <= wdata;
         end
         assign rf[g] = q;
      end
   end

   always_comb begin
      ra_data = '0;
      rb_data = '0;
      for (int i = 0; i < NREG; i++) begin
         if (ra_idx == IDX_W'(i)) ra_data = rf[i];
         if (rb_idx == IDX_W'(i)) rb_data = rf[i];
      end
   end

endmodule

// File: rtl/mthd_maddr.sv
module mthd_maddr #(
   parameter int DATA_W = 32,
   parameter int ADDR_W = 12,
   parameter int INC_W  = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              load,
   input  logic [DATA_W-1:0] load_val,
   input  logic              adv,
   output logic [ADDR_W-1:0] addr,
   output logic [INC_W-1:0]  step
);

   logic [ADDR_W-1:0] addr_q;
   logic [INC_W-1:0]  step_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_q <= '0;
         step_q <= '0;
      end else if (clr) begin
         addr_q <= '0;
         step_q <= '0;
      end else if (load) begin
         addr_q <= load_val[ADDR_W-1:0];
         step_q <= load_val[ADDR_W +: INC_W];
      end else if (adv) begin
         addr_q <= addr_q + ADDR_W'(step_q);
      end
   end

   assign addr = addr_q;
   assign step = step_q;

   // R11
   addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (adv && !load && !clr) |=> (addr_q == ADDR_W'($past(addr_q) + ADDR_W'($past(step_q)))));

   // R11
   step_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (adv && !load && !clr) |=> $stable(step_q));

endmodule

// File: rtl/mthd_ctl.sv
module mthd_ctl
   import mthd_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int IDX_W  = 3,
   parameter int ADDR_W = 12,
   parameter int INC_W  = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_valid,
   output logic              cmd_ready,
   input  logic              cmd_start,
   input  res_op_e           cmd_op,
   input  logic [IDX_W-1:0]  cmd_dst,
   input  logic [DATA_W-1:0] cmd_result,
   input  logic              prm_valid,
   input  logic [DATA_W-1:0] prm_data,
   output logic              prm_pop,
   output logic              snd_valid,
   input  logic              snd_ready,
   output logic [DATA_W-1:0] snd_data,
   output logic              clr,
   output logic              rf_we,
   output logic [IDX_W-1:0]  rf_widx,
   output logic [DATA_W-1:0] rf_wdata,
   output logic              m_load,
   output logic [DATA_W-1:0] m_load_val,
   output logic              m_adv,
   output logic              done
);

   localparam op_ctl_t START_CTL =
      '{fetch: 1'b1, wr_param: 1'b1, load_m: 1'b0, send: 1'b0, src: SS_RESULT};
   localparam logic [IDX_W-1:0] START_DST = IDX_W'(1);

   dsp_state_e        st_q, st_d;
   op_ctl_t           ctl_q;
   logic [IDX_W-1:0]  dst_q;
   logic [DATA_W-1:0] res_q;
   logic [DATA_W-1:0] prm_q;
   logic              done_q;
   logic              accept;
   logic              finish;

   assign accept = (st_q == ST_IDLE) && cmd_valid;

   always_comb begin
      st_d   = st_q;
      finish = 1'b0;
      case (st_q)
         ST_IDLE:  if (cmd_valid) st_d = (cmd_start || decode_op(cmd_op).fetch) ? ST_FETCH : ST_APPLY;
         ST_FETCH: if (prm_valid) st_d = ST_APPLY;
         ST_APPLY: begin
            if (ctl_q.send) st_d = ST_SEND;
            else begin
               st_d   = ST_IDLE;
               finish = 1'b1;
            end
         end
         ST_SEND: if (snd_ready) begin
            st_d   = ST_IDLE;
            finish = 1'b1;
         end
         default: st_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= ST_IDLE;
         ctl_q  <= START_CTL;
         dst_q  <= '0;
         res_q  <= '0;
         prm_q  <= '0;
         done_q <= 1'b0;
      end else begin
         st_q   <= st_d;
         done_q <= finish;
         if (accept) begin
            ctl_q <= cmd_start ? START_CTL : decode_op(cmd_op);
            dst_q <= cmd_start ? START_DST : cmd_dst;
            res_q <= cmd_result;
         end
         if (st_q == ST_FETCH && prm_valid) prm_q <= prm_data;
      end
   end

   assign cmd_ready  = (st_q == ST_IDLE);
   assign clr        = accept && cmd_start;
   assign prm_pop    = (st_q == ST_FETCH) && prm_valid;
   assign rf_we      = (st_q == ST_APPLY);
   assign rf_widx    = dst_q;
   assign rf_wdata   = ctl_q.wr_param ? prm_q : res_q;
   assign m_load     = (st_q == ST_APPLY) && ctl_q.load_m;
   assign m_load_val = res_q;
   assign snd_valid  = (st_q == ST_SEND);
   assign m_adv      = snd_valid && snd_ready;
   assign done       = done_q;

   always_comb begin
      case (ctl_q.src)
         SS_PARAM: snd_data = prm_q;
         SS_STEP:  snd_data = DATA_W'(res_q[ADDR_W +: INC_W]);
         default:  snd_data = res_q;
      endcase
   end

   // R12
   snd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (snd_valid && !snd_ready) |=> (snd_valid && $stable(snd_data)));

   // R12
   pop_needs_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
      prm_pop |-> prm_valid);

   // R12
   pop_send_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({prm_pop, snd_valid}));

   // R13
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R13
   busy_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && cmd_ready) |=> !cmd_ready);

endmodule

// File: rtl/mthd_dispatch.sv
module mthd_dispatch
   import mthd_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int INSN_W = 32,
   parameter int NREG   = 8,
   parameter int ADDR_W = 12,
   parameter int INC_W  = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_valid,
   output logic              cmd_ready,
   input  logic              cmd_start,
   input  logic [INSN_W-1:0] cmd_insn,
   input  logic [DATA_W-1:0] cmd_result,
   output logic [DATA_W-1:0] src_a_data,
   output logic [DATA_W-1:0] src_b_data,
   input  logic              prm_valid,
   input  logic [DATA_W-1:0] prm_data,
   output logic              prm_pop,
   output logic              snd_valid,
   input  logic              snd_ready,
   output logic [ADDR_W-1:0] snd_addr,
   output logic [DATA_W-1:0] snd_data,
   output logic              done
);

   localparam int IDX_W = FLD_W;

   if (INSN_W < INSN_MIN_W) begin : g_bad_insn
      $error("instruction word too narrow for its fields");
   end
   if (NREG < 2 || NREG > (1 << IDX_W)) begin : g_bad_nreg
      $error("register count must fit the 3-bit index and include r1");
   end
   if (DATA_W < ADDR_W + INC_W) begin : g_bad_addr
      $error("data word cannot carry address and step");
   end

   res_op_e           op;
   logic [IDX_W-1:0]  dst, sa, sb;
   logic              clr, rf_we, m_load, m_adv;
   logic [IDX_W-1:0]  rf_widx;
   logic [DATA_W-1:0] rf_wdata, m_load_val;
   logic [INC_W-1:0]  m_step;

   assign op  = res_op_e'(cmd_insn[OP_LSB +: FLD_W]);
   assign dst = cmd_insn[DST_LSB +: FLD_W];
   assign sa  = cmd_insn[SA_LSB +: FLD_W];
   assign sb  = cmd_insn[SB_LSB +: FLD_W];

   mthd_regfile #(.DATA_W(DATA_W), .NREG(NREG), .IDX_W(IDX_W)) u_rf (
      .clk(clk), .rst_n(rst_n), .clr(clr), .we(rf_we), .widx(rf_widx), .wdata(rf_wdata),
      .ra_idx(sa), .rb_idx(sb), .ra_data(src_a_data), .rb_data(src_b_data)
   );

   mthd_maddr #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .INC_W(INC_W)) u_ma (
      .clk(clk), .rst_n(rst_n), .clr(clr), .load(m_load), .load_val(m_load_val),
      .adv(m_adv), .addr(snd_addr), .step(m_step)
   );

   mthd_ctl #(.DATA_W(DATA_W), .IDX_W(IDX_W), .ADDR_W(ADDR_W), .INC_W(INC_W)) u_ctl (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
      .cmd_start(cmd_start), .cmd_op(op), .cmd_dst(dst), .cmd_result(cmd_result),
      .prm_valid(prm_valid), .prm_data(prm_data), .prm_pop(prm_pop),
      .snd_valid(snd_valid), .snd_ready(snd_ready), .snd_data(snd_data),
      .clr(clr), .rf_we(rf_we), .rf_widx(rf_widx), .rf_wdata(rf_wdata),
      .m_load(m_load), .m_load_val(m_load_val), .m_adv(m_adv), .done(done)
   );

   // R12
   addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (snd_valid && !snd_ready) |=> $stable(snd_addr));

   // R11
   step_during_send_chk: assert property (@(posedge clk) disable iff (!rst_n)
      snd_valid |=> $stable(m_step));

endmodule

// File: tb/mthd_dispatch_tb.sv
module mthd_dispatch_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cmd_valid = 1'b0, cmd_ready, cmd_start = 1'b0;
   logic [31:0] cmd_insn = '0, cmd_result = '0;
   logic [31:0] src_a_data, src_b_data;
   logic        prm_valid, prm_pop;
   logic [31:0] prm_data;
   logic        snd_valid, snd_ready = 1'b1;
   logic [11:0] snd_addr;
   logic [31:0] snd_data;
   logic        done;

   always #5 clk = ~clk;

   mthd_dispatch u_dut (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
      .cmd_start(cmd_start), .cmd_insn(cmd_insn), .cmd_result(cmd_result),
      .src_a_data(src_a_data), .src_b_data(src_b_data),
      .prm_valid(prm_valid), .prm_data(prm_data), .prm_pop(prm_pop),
      .snd_valid(snd_valid), .snd_ready(snd_ready), .snd_addr(snd_addr),
      .snd_data(snd_data), .done(done)
   );

   // parameter queue
   logic [31:0] pq [0:63];
   int pq_wr = 0;
   int pq_rd = 0;
   logic pq_en = 1'b1;
   assign prm_valid = pq_en && (pq_rd < pq_wr);
   assign prm_data  = pq[pq_rd[5:0]];
   always @(posedge clk) if (prm_pop) pq_rd <= pq_rd + 1;

   // send log
   int nsent = 0;
   logic [11:0] lg_addr;
   logic [31:0] lg_data;
   always @(posedge clk) if (snd_valid && snd_ready) begin
      nsent   <= nsent + 1;
      lg_addr <= snd_addr;
      lg_data <= snd_data;
   end

   int nchk = 0, nfail = 0, cyc = 0;

   // model
   logic [31:0] m_reg [0:7];
   logic [11:0] m_addr, e_addr;
   logic [5:0]  m_step;
   logic [31:0] e_data;
   int m_prd = 0, m_nsend = 0;

   task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
      nchk++;
      if (got !== exp) begin
         nfail++;
         $display("FAIL %s: got %h expected %h", tag, got, exp);
      end
   endtask

   task automatic push(input logic [31:0] v);
      pq[pq_wr[5:0]] = v;
      pq_wr++;
   endtask

   function automatic logic [31:0] mk_insn(input logic [2:0] op, input logic [2:0] dst,
                                           input logic [2:0] sa, input logic [2:0] sb);
      logic [31:0] w;
      w = '0;
      w[6:4] = op; w[10:8] = dst; w[13:11] = sa; w[16:14] = sb;
      return w;
   endfunction

   task automatic model(input logic st, input logic [2:0] op, input logic [2:0] dst,
                        input logic [31:0] res);
      logic [31:0] p, wv;
      p = '0;
      if (st) begin
         for (int i = 0; i < 8; i++) m_reg[i] = '0;
         m_addr = '0; m_step = '0;
         m_reg[1] = pq[m_prd[5:0]]; m_prd++;
         return;
      end
      if (op inside {3'd0, 3'd3, 3'd5, 3'd6}) begin p = pq[m_prd[5:0]]; m_prd++; end
      wv = (op inside {3'd0, 3'd3, 3'd5}) ? p : res;
      if (dst != 3'd0) m_reg[dst] = wv;
      if (op inside {3'd2, 3'd5, 3'd6, 3'd7}) begin m_addr = res[11:0]; m_step = res[17:12]; end
      if (op inside {3'd3, 3'd4, 3'd6, 3'd7}) begin
         e_data = (op == 3'd6) ? p : (op == 3'd7) ? {26'd0, res[17:12]} : res;
         e_addr = m_addr;
         m_addr = m_addr + 12'(m_step);
         m_nsend++;
      end
   endtask

   task automatic issue(input logic st, input logic [2:0] op, input logic [2:0] dst,
                        input logic [31:0] res);
      @(negedge clk);
      cmd_valid = 1'b1; cmd_start = st; cmd_insn = mk_insn(op, dst, 3'd0, 3'd0); cmd_result = res;
      @(negedge clk);
      cmd_valid = 1'b0; cmd_start = 1'b0;
      model(st, op, dst, res);
   endtask

   task automatic wait_done(input string tag);
      int n = 0;
      while (!done && n < 60) begin @(negedge clk); n++; end
      chk({tag, " done seen"}, {31'd0, done}, 32'd1);
      @(negedge clk);
      chk({tag, " done single cycle"}, {31'd0, done}, 32'd0);
   endtask

   task automatic check_all(input string tag);
      for (int i = 0; i < 8; i++) begin
         cmd_insn = mk_insn(3'd0, 3'd0, 3'(i), 3'(7 - i));
         #1;
         chk($sformatf("%s reg%0d portA", tag, i), src_a_data, m_reg[i]);
         chk($sformatf("%s reg%0d portB", tag, 7 - i), src_b_data, m_reg[7 - i]);
      end
      chk({tag, " send count"}, 32'(nsent), 32'(m_nsend));
      chk({tag, " pops"}, 32'(pq_rd), 32'(m_prd));
   endtask

   task automatic check_send(input string tag);
      chk({tag, " send addr"}, {20'd0, lg_addr}, {20'd0, e_addr});
      chk({tag, " send data"}, lg_data, e_data);
   endtask

   task automatic run(input string tag, input logic st, input logic [2:0] op,
                      input logic [2:0] dst, input logic [31:0] res, input logic sends);
      issue(st, op, dst, res);
      wait_done(tag);
      check_all(tag);
      if (sends) check_send(tag);
   endtask

   task automatic t_reset;
      chk("R1 cmd_ready", {31'd0, cmd_ready}, 32'd1);
      chk("R1 done", {31'd0, done}, 32'd0);
      chk("R1 snd_valid", {31'd0, snd_valid}, 32'd0);
      chk("R1 prm_pop", {31'd0, prm_pop}, 32'd0);
      check_all("R1 R3 reset regs");
   endtask

   task automatic t_ops;
      push(32'hA5A5_0001);
      run("R2 start", 1'b1, 3'd0, 3'd0, 32'h0, 1'b0);
      run("R4 op1 move", 1'b0, 3'd1, 3'd3, 32'h1234_5678, 1'b0);
      push(32'h0000_CAFE);
      run("R4 op0 fetch", 1'b0, 3'd0, 3'd4, 32'hDEAD_0000, 1'b0);
      run("R5 op2 load", 1'b0, 3'd2, 3'd5, (32'd2 << 12) | 32'h100, 1'b0);
      run("R6 op4 send", 1'b0, 3'd4, 3'd6, 32'h55, 1'b1);
      push(32'h77);
      run("R6 op3 fetch send", 1'b0, 3'd3, 3'd7, 32'h99, 1'b1);
      push(32'h31);
      run("R7 op5 fetch load", 1'b0, 3'd5, 3'd2, (32'd1 << 12) | 32'h200, 1'b0);
      run("R7 R11 send after op5", 1'b0, 3'd4, 3'd2, 32'hAB, 1'b1);
      push(32'hBEEF);
      run("R8 op6", 1'b0, 3'd6, 3'd3, (32'd3 << 12) | 32'h300, 1'b1);
      run("R9 op7", 1'b0, 3'd7, 3'd4, (32'h2A << 12) | 32'h010, 1'b1);
      run("R11 step after op7", 1'b0, 3'd4, 3'd1, 32'h4444, 1'b1);
   endtask

   task automatic t_r0;
      run("R10 move to r0", 1'b0, 3'd1, 3'd0, 32'hFFFF_FFFF, 1'b0);
      push(32'h1357);
      run("R10 fetch send r0", 1'b0, 3'd3, 3'd0, 32'h2468, 1'b1);
   endtask

   task automatic t_wrap;
      run("R11 wrap load", 1'b0, 3'd2, 3'd1, (32'd5 << 12) | 32'hFFE, 1'b0);
      run("R11 wrap send1", 1'b0, 3'd4, 3'd6, 32'h1, 1'b1);
      chk("R11 first addr", {20'd0, lg_addr}, 32'hFFE);
      run("R11 wrap send2", 1'b0, 3'd4, 3'd6, 32'h2, 1'b1);
      chk("R11 wrapped addr", {20'd0, lg_addr}, 32'h003);
   endtask

   task automatic t_stall_fetch;
      pq_en = 1'b0;
      push(32'h0BAD_F00D);
      issue(1'b0, 3'd0, 3'd5, 32'h0);
      for (int i = 0; i < 4; i++) begin
         @(negedge clk);
         chk("R12 no pop while empty", {31'd0, prm_pop}, 32'd0);
         chk("R13 busy while stalled", {30'd0, done, cmd_ready}, 32'd0);
      end
      pq_en = 1'b1;
      wait_done("R12 fetch stall");
      check_all("R12 fetch stall");
   endtask

   task automatic t_stall_send;
      logic [11:0] a0;
      logic [31:0] d0;
      snd_ready = 1'b0;
      issue(1'b0, 3'd4, 3'd7, 32'h600D_0001);
      @(negedge clk);
      @(negedge clk);
      a0 = snd_addr; d0 = snd_data;
      for (int i = 0; i < 4; i++) begin
         @(negedge clk);
         chk("R12 valid held", {31'd0, snd_valid}, 32'd1);
         chk("R12 addr held", {20'd0, snd_addr}, {20'd0, a0});
         chk("R12 data held", snd_data, d0);
         chk("R13 no done while stalled", {31'd0, done}, 32'd0);
      end
      snd_ready = 1'b1;
      wait_done("R12 send stall");
      check_all("R12 send stall");
      check_send("R12 send stall");
   endtask

   task automatic t_restart;
      push(32'h0000_0F0F);
      run("R2 restart clears", 1'b1, 3'd7, 3'd6, 32'hFFFF_FFFF, 1'b0);
      run("R2 R11 addr cleared", 1'b0, 3'd4, 3'd2, 32'h9, 1'b1);
   endtask

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc > 100000) begin
         nfail++;
         nchk++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < 8; i++) m_reg[i] = '0;
      m_addr = '0; m_step = '0; e_addr = '0; e_data = '0;
      for (int i = 0; i < 64; i++) pq[i] = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset;
      t_ops;
      t_r0;
      t_wrap;
      t_stall_fetch;
      t_stall_send;
      t_restart;
      $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
   end

endmodule